// File: doc/BRIEF.md
# Dual-Port RAM with Independent Port Aspect Ratios and Byte Parity

This block is a synchronous two-port memory built around a fixed store of 16,384 data bits plus 2,048 parity bits. Each of the two ports is given its own total width by a parameter, chosen from 1, 2, 4, 9, 18 or 36 bits. The address width of a port follows from that choice: it is 14 minus log2 of the port's data-only width. Widths of 9 bits and more carry one parity bit per data byte. The narrow widths carry data only.

Both ports look at the same storage, so the block performs bus matching. A wide port sees several narrow words packed together, with the lowest narrow address in the least significant bits. A narrow port sees one slice of a wide word. Parity bits are placed in storage the same way as their bytes, so a parity bit stays with its own byte when the same data is read at a different width. A width outside the legal set stops elaboration with an error.

Both ports work on the rising edge of one shared clock. Each has an enable, a write enable, an address, data and parity inputs, and registered data and parity outputs. A read returns its data one cycle after the enabled edge. On a write, the port's own output shows the newly written word. If both ports write the same bit at the same edge, the stored result is undefined, and users must avoid this case.

Top module: `dpr_asym_ram`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, all data and parity outputs of both ports become zero at the next edge.
- R2: A port whose data-only width is DW has an address of 14 - log2(DW) bits. Every one of its 16384/DW addresses selects distinct storage, so writing all of them and reading them back returns each word unchanged.
- R3: A read enabled at a clock edge presents the addressed word on the port's outputs after that same edge. Back-to-back reads on consecutive cycles each return their own word.
- R4: A write enabled at an edge stores the word, and after that edge the same port's outputs show the written data and parity (write-first).
- R5: With the enable low, a port neither writes nor changes its outputs, whatever its write enable, address and data inputs are.
- R6: Data bit i of the word at address n on a port of data width DW is storage data bit n*DW+i. A wide word therefore holds consecutive narrow words, with the lowest narrow address in the least significant bits.
- R7: Parity bit j of the word at address n on a port with P parity bits is storage parity bit n*P+j. Parity bit k of a wide word thus stays with data byte k when the word is read as 18-bit or 9-bit words.
- R8: A port of width 1, 2 or 4 has a single parity output bit that always reads zero. Its writes leave the parity storage untouched.
- R9: Both ports act at the same edge. When one port reads storage that the other port writes at that edge, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | A_AW | Port A word address |
| a_din | input | A_DW | Port A write data |
| a_pin | input | A_PPW | Port A write parity (ignored for widths 1, 2, 4) |
| a_dout | output | A_DW | Port A read data |
| a_pout | output | A_PPW | Port A read parity (zero for widths 1, 2, 4) |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | B_AW | Port B word address |
| b_din | input | B_DW | Port B write data |
| b_pin | input | B_PPW | Port B write parity (ignored for widths 1, 2, 4) |
| b_dout | output | B_DW | Port B read data |
| b_pout | output | B_PPW | Port B read parity (zero for widths 1, 2, 4) |

## Verification
Two instances are exercised: one pairs a 9-bit port with a 36-bit port, and one pairs a 2-bit port with an 18-bit port. A sequential fill through the wide port, followed by a full read-back at both widths, separates address-slicing and lane-order errors from plain storage faults. Directed cases then cover the following: a known 36-bit word with a mixed parity pattern read back byte by byte, which exposes parity lanes that are swapped or shifted; data-only writes over a word that holds parity, which exposes parity corruption; and a same-edge read of a row the other port is writing. A long random mix with both ports active checks concurrent access, enable gating and output hold against a bit-level model of the linear address mapping.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int ROWS      = 512;
  localparam int ROW_AW    = 9;
  localparam int ROW_DBITS = 32;
  localparam int ROW_PBITS = 4;

  function automatic bit legal_width(input int w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18) || (w == 36);
  endfunction

  function automatic int data_bits(input int w);
    return (w >= 9) ? (w / 9) * 8 : w;
  endfunction

  function automatic int par_bits(input int w);
    return (w >= 9) ? w / 9 : 0;
  endfunction

  function automatic int par_port_bits(input int w);
    return (w >= 9) ? w / 9 : 1;
  endfunction

  function automatic int addr_bits(input int w);
    return 14 - $clog2(data_bits(w));
  endfunction
endpackage

// File: rtl/dpr_lane.sv
module dpr_lane #(
  parameter int W   = 9,
  parameter int AW  = 11,
  parameter int DW  = 8,
  parameter int PPW = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  input  logic [AW-1:0]                 addr,
  input  logic [DW-1:0]                 din,
  input  logic [PPW-1:0]                pin,
  input  logic [dpr_pkg::ROW_DBITS-1:0] rd_d_row,
  input  logic [dpr_pkg::ROW_PBITS-1:0] rd_p_row,
  output logic [dpr_pkg::ROW_AW-1:0]    row,
  output logic [dpr_pkg::ROW_DBITS-1:0] wr_d,
  output logic [dpr_pkg::ROW_DBITS-1:0] wr_dm,
  output logic [dpr_pkg::ROW_PBITS-1:0] wr_p,
  output logic [dpr_pkg::ROW_PBITS-1:0] wr_pm,
  output logic [DW-1:0]                 dout,
  output logic [PPW-1:0]                pout
);
  import dpr_pkg::*;

  localparam int PW  = par_bits(W);
  localparam int SB  = AW - ROW_AW;
  localparam int SLW = (SB > 0) ? SB : 1;

  logic [SLW-1:0] slot;
  logic [SLW-1:0] slot_q;

  // Upper address bits pick the storage row, lower bits pick the lane.
  generate
    if (SB > 0) begin : g_split
      assign row  = addr[AW-1:SB];
      assign slot = addr[SB-1:0];
    end else begin : g_whole
      assign row  = addr;
      assign slot = '0;
    end
  endgenerate

  // The lane of the read is kept for the slice after the row register.
  always_ff @(posedge clk) begin
    if (rst)     slot_q <= '0;
    else if (en) slot_q <= slot;
  end

  always_comb begin
    wr_d  = '0;
    wr_dm = '0;
    wr_d[int'(slot)*DW +: DW]  = din;
    wr_dm[int'(slot)*DW +: DW] = '1;
    dout = rd_d_row[int'(slot_q)*DW +: DW];
  end

  generate
    if (PW > 0) begin : g_par
      always_comb begin
        wr_p  = '0;
        wr_pm = '0;
        wr_p[int'(slot)*PW +: PW]  = pin;
        wr_pm[int'(slot)*PW +: PW] = '1;
        pout = rd_p_row[int'(slot_q)*PW +: PW];
      end
    end else begin : g_nopar
      logic unused_par;
      assign unused_par = ^{pin, rd_p_row};
      assign wr_p  = '0;
      assign wr_pm = '0;
      assign pout  = '0;
    end
  endgenerate
endmodule

// File: rtl/dpr_store.sv
module dpr_store (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en_a,
  input  logic                          we_a,
  input  logic [dpr_pkg::ROW_AW-1:0]    row_a,
  input  logic [dpr_pkg::ROW_DBITS-1:0] wd_a,
  input  logic [dpr_pkg::ROW_DBITS-1:0] wm_a,
  input  logic [dpr_pkg::ROW_PBITS-1:0] wp_a,
  input  logic [dpr_pkg::ROW_PBITS-1:0] wpm_a,
  input  logic                          en_b,
  input  logic                          we_b,
  input  logic [dpr_pkg::ROW_AW-1:0]    row_b,
  input  logic [dpr_pkg::ROW_DBITS-1:0] wd_b,
  input  logic [dpr_pkg::ROW_DBITS-1:0] wm_b,
  input  logic [dpr_pkg::ROW_PBITS-1:0] wp_b,
  input  logic [dpr_pkg::ROW_PBITS-1:0] wpm_b,
  output logic [dpr_pkg::ROW_DBITS-1:0] q_da,
  output logic [dpr_pkg::ROW_PBITS-1:0] q_pa,
  output logic [dpr_pkg::ROW_DBITS-1:0] q_db,
  output logic [dpr_pkg::ROW_PBITS-1:0] q_pb
);
  import dpr_pkg::*;

  logic [ROW_DBITS-1:0] dmem [ROWS];
  logic [ROW_PBITS-1:0] pmem [ROWS];

  logic                 wr_a, wr_b, same_row;
  logic [ROW_DBITS-1:0] new_da, base_db, new_db;
  logic [ROW_PBITS-1:0] new_pa, base_pb, new_pb;

  assign wr_a     = en_a && we_a;
  assign wr_b     = en_b && we_b;
  assign same_row = wr_a && (row_a == row_b);

  // Lane merges; a port-B write on the row port A writes builds on A's result.
  always_comb begin
    new_da  = (dmem[row_a] & ~wm_a) | (wd_a & wm_a);
    new_pa  = (pmem[row_a] & ~wpm_a) | (wp_a & wpm_a);
    base_db = same_row ? new_da : dmem[row_b];
    base_pb = same_row ? new_pa : pmem[row_b];
    new_db  = (base_db & ~wm_b) | (wd_b & wm_b);
    new_pb  = (base_pb & ~wpm_b) | (wp_b & wpm_b);
  end

  always_ff @(posedge clk) begin
    if (wr_a) begin
      dmem[row_a] <= new_da;
      pmem[row_a] <= new_pa;
    end
    if (wr_b) begin
      dmem[row_b] <= new_db;
      pmem[row_b] <= new_pb;
    end
  end

  // Row registers: write-first for the own port, old contents otherwise.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_da <= '0;
      q_pa <= '0;
    end else if (en_a) begin
      q_da <= we_a ? new_da : dmem[row_a];
      q_pa <= we_a ? new_pa : pmem[row_a];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_db <= '0;
      q_pb <= '0;
    end else if (en_b) begin
      q_db <= we_b ? new_db : dmem[row_b];
      q_pb <= we_b ? new_pb : pmem[row_b];
    end
  end
endmodule

// File: rtl/dpr_asym_ram.sv
module dpr_asym_ram #(
  parameter int A_WIDTH = 9,
  parameter int B_WIDTH = 36,
  parameter int A_DW    = dpr_pkg::data_bits(A_WIDTH),
  parameter int A_PPW   = dpr_pkg::par_port_bits(A_WIDTH),
  parameter int A_AW    = dpr_pkg::addr_bits(A_WIDTH),
  parameter int B_DW    = dpr_pkg::data_bits(B_WIDTH),
  parameter int B_PPW   = dpr_pkg::par_port_bits(B_WIDTH),
  parameter int B_AW    = dpr_pkg::addr_bits(B_WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_en,
  input  logic             a_we,
  input  logic [A_AW-1:0]  a_addr,
  input  logic [A_DW-1:0]  a_din,
  input  logic [A_PPW-1:0] a_pin,
  output logic [A_DW-1:0]  a_dout,
  output logic [A_PPW-1:0] a_pout,
  input  logic             b_en,
  input  logic             b_we,
  input  logic [B_AW-1:0]  b_addr,
  input  logic [B_DW-1:0]  b_din,
  input  logic [B_PPW-1:0] b_pin,
  output logic [B_DW-1:0]  b_dout,
  output logic [B_PPW-1:0] b_pout
);
  import dpr_pkg::*;

  generate
    if (!legal_width(A_WIDTH) || !legal_width(B_WIDTH)) begin : g_bad_width
      $error("dpr_asym_ram: port width must be 1, 2, 4, 9, 18 or 36");
    end
  endgenerate

  logic [ROW_AW-1:0]    row_a, row_b;
  logic [ROW_DBITS-1:0] wd_a, wm_a, wd_b, wm_b, q_da, q_db;
  logic [ROW_PBITS-1:0] wp_a, wpm_a, wp_b, wpm_b, q_pa, q_pb;

  dpr_lane #(.W(A_WIDTH), .AW(A_AW), .DW(A_DW), .PPW(A_PPW)) u_lane_a (
    .clk(clk), .rst(rst), .en(a_en), .addr(a_addr), .din(a_din), .pin(a_pin),
    .rd_d_row(q_da), .rd_p_row(q_pa), .row(row_a),
    .wr_d(wd_a), .wr_dm(wm_a), .wr_p(wp_a), .wr_pm(wpm_a),
    .dout(a_dout), .pout(a_pout)
  );

  dpr_lane #(.W(B_WIDTH), .AW(B_AW), .DW(B_DW), .PPW(B_PPW)) u_lane_b (
    .clk(clk), .rst(rst), .en(b_en), .addr(b_addr), .din(b_din), .pin(b_pin),
    .rd_d_row(q_db), .rd_p_row(q_pb), .row(row_b),
    .wr_d(wd_b), .wr_dm(wm_b), .wr_p(wp_b), .wr_pm(wpm_b),
    .dout(b_dout), .pout(b_pout)
  );

  dpr_store u_store (
    .clk(clk), .rst(rst),
    .en_a(a_en), .we_a(a_we), .row_a(row_a), .wd_a(wd_a), .wm_a(wm_a), .wp_a(wp_a), .wpm_a(wpm_a),
    .en_b(b_en), .we_b(b_we), .row_b(row_b), .wd_b(wd_b), .wm_b(wm_b), .wp_b(wp_b), .wpm_b(wpm_b),
    .q_da(q_da), .q_pa(q_pa), .q_db(q_db), .q_pb(q_pb)
  );
endmodule

// File: rtl/dpr_asym_ram_chk.sv
module dpr_asym_ram_chk #(
  parameter int A_DW  = 8,
  parameter int A_PPW = 1,
  parameter int A_PW  = 1,
  parameter int B_DW  = 32,
  parameter int B_PPW = 4,
  parameter int B_PW  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             a_en,
  input logic             a_we,
  input logic [A_DW-1:0]  a_din,
  input logic [A_PPW-1:0] a_pin,
  input logic [A_DW-1:0]  a_dout,
  input logic [A_PPW-1:0] a_pout,
  input logic             b_en,
  input logic             b_we,
  input logic [B_DW-1:0]  b_din,
  input logic [B_PPW-1:0] b_pin,
  input logic [B_DW-1:0]  b_dout,
  input logic [B_PPW-1:0] b_pout
);
  // R1
  reset_clears_a_chk: assert property (@(posedge clk) rst |=> (a_dout == '0 && a_pout == '0));
  // R1
  reset_clears_b_chk: assert property (@(posedge clk) rst |=> (b_dout == '0 && b_pout == '0));
  // R4
  write_first_a_chk: assert property (@(posedge clk) disable iff (rst)
    (a_en && a_we) |=> (a_dout == $past(a_din) && (A_PW == 0 || a_pout == $past(a_pin))));
  // R4
  write_first_b_chk: assert property (@(posedge clk) disable iff (rst)
    (b_en && b_we) |=> (b_dout == $past(b_din) && (B_PW == 0 || b_pout == $past(b_pin))));
  // R5
  idle_hold_a_chk: assert property (@(posedge clk) disable iff (rst)
    !a_en |=> ($stable(a_dout) && $stable(a_pout)));
  // R5
  idle_hold_b_chk: assert property (@(posedge clk) disable iff (rst)
    !b_en |=> ($stable(b_dout) && $stable(b_pout)));
endmodule

bind dpr_asym_ram dpr_asym_ram_chk #(
  .A_DW(A_DW), .A_PPW(A_PPW), .A_PW(dpr_pkg::par_bits(A_WIDTH)),
  .B_DW(B_DW), .B_PPW(B_PPW), .B_PW(dpr_pkg::par_bits(B_WIDTH))
) u_chk (
  .clk(clk), .rst(rst),
  .a_en(a_en), .a_we(a_we), .a_din(a_din), .a_pin(a_pin), .a_dout(a_dout), .a_pout(a_pout),
  .b_en(b_en), .b_we(b_we), .b_din(b_din), .b_pin(b_pin), .b_dout(b_dout), .b_pout(b_pout)
);

// File: tb/tb_dpr_asym_ram.sv
module tb_dpr_asym_ram;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  // Instance 0: 9-bit port A, 36-bit port B. Instance 1: 2-bit port A, 18-bit port B.
  logic        a0_en, a0_we, b0_en, b0_we, a1_en, a1_we, b1_en, b1_we;
  logic [10:0] a0_addr;  logic [7:0]  a0_din, a0_dout;  logic [0:0] a0_pin, a0_pout;
  logic [8:0]  b0_addr;  logic [31:0] b0_din, b0_dout;  logic [3:0] b0_pin, b0_pout;
  logic [12:0] a1_addr;  logic [1:0]  a1_din, a1_dout;  logic [0:0] a1_pin, a1_pout;
  logic [9:0]  b1_addr;  logic [15:0] b1_din, b1_dout;  logic [1:0] b1_pin, b1_pout;

  dpr_asym_ram #(.A_WIDTH(9), .B_WIDTH(36)) dut (
    .clk(clk), .rst(rst),
    .a_en(a0_en), .a_we(a0_we), .a_addr(a0_addr), .a_din(a0_din), .a_pin(a0_pin),
    .a_dout(a0_dout), .a_pout(a0_pout),
    .b_en(b0_en), .b_we(b0_we), .b_addr(b0_addr), .b_din(b0_din), .b_pin(b0_pin),
    .b_dout(b0_dout), .b_pout(b0_pout));

  dpr_asym_ram #(.A_WIDTH(2), .B_WIDTH(18)) dut2 (
    .clk(clk), .rst(rst),
    .a_en(a1_en), .a_we(a1_we), .a_addr(a1_addr), .a_din(a1_din), .a_pin(a1_pin),
    .a_dout(a1_dout), .a_pout(a1_pout),
    .b_en(b1_en), .b_we(b1_we), .b_addr(b1_addr), .b_din(b1_din), .b_pin(b1_pin),
    .b_dout(b1_dout), .b_pout(b1_pout));

  int checks = 0;
  int fails  = 0;
  string cur_req = "R2";

  bit md [2][16384];
  bit mp [2][2048];

  logic        en_v  [2][2];
  logic        we_v  [2][2];
  int unsigned adr_v [2][2];
  logic [31:0] din_v [2][2];
  logic [3:0]  pin_v [2][2];
  logic [31:0] exp_d [2][2];
  logic [3:0]  exp_p [2][2];

  function automatic int pdw(input int i, input int p);
    if (i == 0) return (p == 0) ? 8 : 32;
    return (p == 0) ? 2 : 16;
  endfunction

  function automatic int ppw(input int i, input int p);
    if (i == 0) return (p == 0) ? 1 : 4;
    return (p == 0) ? 0 : 2;
  endfunction

  function automatic int paw(input int i, input int p);
    return 14 - $clog2(pdw(i, p));
  endfunction

  function automatic logic [31:0] msk(input int n);
    return 32'((64'd1 << n) - 64'd1);
  endfunction

  function automatic logic [35:0] got(input int i, input int p);
    if (i == 0 && p == 0) return {4'(a0_pout), 32'(a0_dout)};
    if (i == 0)           return {4'(b0_pout), 32'(b0_dout)};
    if (p == 0)           return {4'(a1_pout), 32'(a1_dout)};
    return {4'(b1_pout), 32'(b1_dout)};
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic idle_all();
    for (int i = 0; i < 2; i++)
      for (int p = 0; p < 2; p++) begin
        en_v[i][p] = 1'b0; we_v[i][p] = 1'b0; adr_v[i][p] = 0;
        din_v[i][p] = '0; pin_v[i][p] = '0;
      end
  endtask

  task automatic setop(input int i, input int p, input bit en, input bit we,
                       input int unsigned a, input logic [31:0] d, input logic [3:0] pp);
    en_v[i][p]  = en;
    we_v[i][p]  = we;
    adr_v[i][p] = a;
    din_v[i][p] = d & msk(pdw(i, p));
    pin_v[i][p] = pp & 4'(msk(ppw(i, p)));
  endtask

  task automatic drive();
    a0_en = en_v[0][0]; a0_we = we_v[0][0]; a0_addr = 11'(adr_v[0][0]);
    a0_din = 8'(din_v[0][0]); a0_pin = 1'(pin_v[0][0]);
    b0_en = en_v[0][1]; b0_we = we_v[0][1]; b0_addr = 9'(adr_v[0][1]);
    b0_din = din_v[0][1]; b0_pin = pin_v[0][1];
    a1_en = en_v[1][0]; a1_we = we_v[1][0]; a1_addr = 13'(adr_v[1][0]);
    a1_din = 2'(din_v[1][0]); a1_pin = 1'(pin_v[1][0]);
    b1_en = en_v[1][1]; b1_we = we_v[1][1]; b1_addr = 10'(adr_v[1][1]);
    b1_din = 16'(din_v[1][1]); b1_pin = 2'(pin_v[1][1]);
  endtask

  task automatic check_all();
    for (int i = 0; i < 2; i++)
      for (int p = 0; p < 2; p++) begin
        string t;
        logic [35:0] g, e;
        t = !en_v[i][p] ? "R5" : (we_v[i][p] ? "R4" : cur_req);
        g = got(i, p);
        e = {exp_p[i][p], exp_d[i][p]};
        checks++;
        if (g !== e) begin
          fails++;
          $display("FAIL %s inst%0d port%0d addr %0d: got %h expected %h",
                   t, i, p, adr_v[i][p], g, e);
        end
      end
  endtask

  // One clock: expectations from the model before this edge's writes, then writes.
  task automatic cycle();
    for (int i = 0; i < 2; i++)
      for (int p = 0; p < 2; p++)
        if (en_v[i][p]) begin
          if (we_v[i][p]) begin
            exp_d[i][p] = din_v[i][p];
            exp_p[i][p] = pin_v[i][p];
          end else begin
            exp_d[i][p] = '0;
            exp_p[i][p] = '0;
            for (int b = 0; b < pdw(i, p); b++)
              exp_d[i][p][b] = md[i][adr_v[i][p] * pdw(i, p) + b];
            for (int b = 0; b < ppw(i, p); b++)
              exp_p[i][p][b] = mp[i][adr_v[i][p] * ppw(i, p) + b];
          end
        end
    for (int i = 0; i < 2; i++)
      for (int p = 0; p < 2; p++)
        if (en_v[i][p] && we_v[i][p]) begin
          for (int b = 0; b < pdw(i, p); b++)
            md[i][adr_v[i][p] * pdw(i, p) + b] = din_v[i][p][b];
          for (int b = 0; b < ppw(i, p); b++)
            mp[i][adr_v[i][p] * ppw(i, p) + b] = pin_v[i][p][b];
        end
    drive();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    idle_all();
    // R1: reset dominates even with reads requested
    for (int i = 0; i < 2; i++)
      for (int p = 0; p < 2; p++) en_v[i][p] = 1'b1;
    drive();
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++)
      for (int p = 0; p < 2; p++) begin
        checks++;
        if (got(i, p) !== 36'd0) begin
          fails++;
          $display("FAIL R1 inst%0d port%0d: got %h expected %h", i, p, got(i, p), 36'd0);
        end
        exp_d[i][p] = '0;
        exp_p[i][p] = '0;
      end
    idle_all();
    drive();
    rst = 1'b0;
    @(negedge clk);

    // R2: fill every wide address, then read all back on the wide port
    for (int k = 0; k < 1024; k++) begin
      idle_all();
      if (k < 512) setop(0, 1, 1, 1, k, $urandom, 4'($urandom));
      setop(1, 1, 1, 1, k, $urandom, 4'($urandom));
      cycle();
    end
    cur_req = "R2";
    for (int k = 0; k < 1024; k++) begin
      idle_all();
      if (k < 512) setop(0, 1, 1, 0, k, 0, 0);
      setop(1, 1, 1, 0, k, 0, 0);
      cycle();
    end

    // R6: sweep every narrow address over the wide-written contents
    cur_req = "R6";
    for (int k = 0; k < 8192; k++) begin
      idle_all();
      if (k < 2048) setop(0, 0, 1, 0, k, 0, 0);
      setop(1, 0, 1, 0, k, 0, 0);
      cycle();
    end

    // R7: 36-bit word with mixed parity, read as four 9-bit words
    cur_req = "R7";
    idle_all();
    setop(0, 1, 1, 1, 5, 32'h44332211, 4'b1010);
    cycle();
    for (int k = 20; k < 24; k++) begin
      idle_all();
      setop(0, 0, 1, 0, k, 0, 0);
      cycle();
      checks++;
      if (a0_dout !== 8'(8'h11 * (k - 19)) || a0_pout !== 1'(k == 21 || k == 23)) begin
        fails++;
        $display("FAIL R7 byte %0d: got %h/%b expected %h/%b", k - 20, a0_dout, a0_pout,
                 8'(8'h11 * (k - 19)), 1'(k == 21 || k == 23));
      end
    end

    // R8: 2-bit writes over an 18-bit word leave its parity alone
    cur_req = "R8";
    idle_all();
    setop(1, 1, 1, 1, 3, 32'hABCD, 4'b11);
    cycle();
    for (int k = 24; k < 32; k++) begin
      idle_all();
      setop(1, 0, 1, 1, k, $urandom, 4'hF);
      cycle();
    end
    idle_all();
    setop(1, 1, 1, 0, 3, 0, 0);
    cycle();
    checks++;
    if (b1_pout !== 2'b11 || a1_pout !== 1'b0) begin
      fails++;
      $display("FAIL R8 parity: got %b/%b expected 11/0", b1_pout, a1_pout);
    end

    // R3: back-to-back reads on consecutive cycles
    cur_req = "R3";
    for (int k = 7; k < 11; k++) begin
      idle_all();
      setop(0, 1, 1, 0, k, 0, 0);
      setop(1, 1, 1, 0, k + 100, 0, 0);
      cycle();
    end

    // R9: read of a row the other port writes at the same edge returns old data
    cur_req = "R9";
    idle_all();
    setop(0, 0, 1, 1, 100, 8'h5A, 1'b1);
    setop(0, 1, 1, 0, 25, 0, 0);
    cycle();
    idle_all();
    setop(0, 1, 1, 0, 25, 0, 0);
    cycle();

    // R9: random two-port mix, overlapping writes avoided
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < 2; i++) begin
        for (int p = 0; p < 2; p++)
          setop(i, p, ($urandom % 4) != 0, $urandom % 2,
                $urandom % (1 << paw(i, p)), $urandom, 4'($urandom));
        if (en_v[i][0] && we_v[i][0] && en_v[i][1] && we_v[i][1]) begin
          int unsigned lo0, lo1;
          lo0 = adr_v[i][0] * pdw(i, 0);
          lo1 = adr_v[i][1] * pdw(i, 1);
          if (lo0 < lo1 + pdw(i, 1) && lo1 < lo0 + pdw(i, 0)) we_v[i][1] = 1'b0;
        end
      end
      cycle();
    end

    summary();
    $finish;
  end
endmodule